// File: doc/BRIEF.md
# Two-Wire Bus Master Interrupt Status Unit

This unit holds the interrupt status of the command most recently issued by a two-wire serial bus master. It collects single-cycle event strobes from the master's control logic, two bus-clock-low watchdog timers that it owns, and a receive-FIFO pressure condition. From these it keeps a 16-bit status word, exposed as the low half of a 32-bit read value. It also drives one registered interrupt line.

Event bits are sticky. A register read clears them, and so does the start of a new command. If an event arrives in the same cycle as a clear, the event is kept. The receive-pressure bit works differently: it follows its condition. It is set while a receive transfer is active, the FIFO holds at least four bytes, and more bytes are still due than the FIFO has free slots. It drops as soon as that condition fails, or at once when an abnormal end flushes the FIFO.

Top module: `tw_irq_status`

## Requirements
- R1: After reset, `rd_data_o` and `irq_o` are zero. Bits [31:16] of `rd_data_o` always read zero.
- R2: A 1 on `evt_i[k]` sets status bit 4+k (bits [12:4]), and a 1 on `info_i[k]` sets status bit k (bits [3:0]). Both groups hold their value until cleared. Bits [3:0] are not interrupt sources.
- R3: `rd_data_o` shows the status before the clear. At the clock edge where `rd_en_i` is 1, all status bits clear.
- R4: At the clock edge where `cmd_start_i` is 1, all status bits clear.
- R5: A bit that is being set in the same cycle as a read or a new-command clear ends up set.
- R6: Bit 15 sets at the edge that ends the LOW_LIMIT-th consecutive cycle with `scl_low_i` and `bus_owned_i` both 1. If either input drops, the count restarts. Only one set happens per low period.
- R7: Bit 14 follows the same rule as R6, using EXT_LIMIT.
- R8: Bit 13 is, one edge later, the value of this condition: `rx_mode_i` is not 0 (1 = manual, 2 = automatic, 3 = sequence), `rx_count_i` >= 4, and `rx_remain_i` > DEPTH - `rx_count_i`.
- R9: Bit 13 clears at the next edge after its condition fails, or while `rx_flush_i` is 1, even if the condition holds.
- R10: `irq_o` is registered. At each edge it takes the value of `irq_en_i` AND (any of status bits [15:4]). It therefore rises one cycle after a source bit sets and falls one cycle after the sources clear or the enable drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_low_i | input | 1 | Bus clock line is currently low |
| bus_owned_i | input | 1 | This master controls the bus |
| cmd_start_i | input | 1 | New command issued (clears status) |
| rx_mode_i | input | 2 | Receive transfer kind: 0 none, 1 manual, 2 automatic, 3 sequence |
| rx_count_i | input | $clog2(DEPTH+1) | Bytes held in the receive FIFO |
| rx_remain_i | input | REM_W | Bytes still to be received |
| rx_flush_i | input | 1 | Abnormal completion, receive FIFO flushed |
| evt_i | input | 9 | Sticky interrupt-source events for bits [12:4] |
| info_i | input | 4 | Sticky non-interrupt events for bits [3:0] |
| irq_en_i | input | 1 | Interrupt enable |
| rd_en_i | input | 1 | Status read strobe (clear on read) |
| rd_data_o | output | 32 | Status read value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with DEPTH = 8, LOW_LIMIT = 12 and EXT_LIMIT = 30. The short limits let it check both timeout bits at the exact edge where they set, and one edge before it, in a few dozen cycles. It can also break a low period just short of the limit to show that the count restarts. With the 8-entry FIFO, the free-slot comparison can be tested at its boundaries: equal versus one more, and a full FIFO. The same bench also covers receive modes with the condition both on and off.

// File: rtl/tw_irq_pkg.sv
package tw_irq_pkg;
  localparam int STAT_W   = 16;
  localparam int REG_W    = 32;
  localparam int EVT_W    = 9;
  localparam int INFO_W   = 4;
  localparam int SRC_LSB  = 4;
  localparam int BIT_RXHI = 13;
  localparam int BIT_TEXT = 14;
  localparam int BIT_TLOW = 15;
  localparam int N_TMR    = 2;

  typedef enum logic [1:0] {
    RX_NONE   = 2'd0,
    RX_MANUAL = 2'd1,
    RX_AUTO   = 2'd2,
    RX_SEQ    = 2'd3
  } rx_mode_e;
endpackage

// File: rtl/tw_low_timer.sv
module tw_low_timer #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so one low period yields one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/tw_rx_hi.sv
module tw_rx_hi
  import tw_irq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int HI_LEVEL = 4,
  parameter int REM_W    = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int FW      = REM_W + 1
) (
  input  logic [1:0]       rx_mode_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [REM_W-1:0] rx_remain_i,
  output logic             hi_o
);
  logic [FW-1:0] free_w;
  logic          active_w;

  assign active_w = rx_mode_e'(rx_mode_i) != RX_NONE;
  assign free_w   = (rx_count_i >= CNT_W'(DEPTH)) ? '0
                  : FW'(CNT_W'(DEPTH) - rx_count_i);
  assign hi_o     = active_w && (rx_count_i >= CNT_W'(HI_LEVEL))
                  && ({1'b0, rx_remain_i} > free_w);
endmodule

// File: rtl/tw_stat_reg.sv
module tw_stat_reg
  import tw_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic              lvl_i,
  output logic [STAT_W-1:0] stat_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == BIT_RXHI) begin : g_lvl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_o[b] <= 1'b0;
        else         stat_o[b] <= lvl_i;
      end
    end else begin : g_sticky
      // set has priority over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_o[b] <= 1'b0;
        else         stat_o[b] <= set_i[b] | (stat_o[b] & ~clr_i);
      end
    end
  end
endmodule

// File: rtl/tw_irq_out.sv
module tw_irq_out #(
  parameter int SRC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= en_i & (|src_i);
  end
endmodule

// File: rtl/tw_irq_status.sv
module tw_irq_status
  import tw_irq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int HI_LEVEL  = 4,
  parameter int REM_W     = 16,
  parameter int LOW_LIMIT = 1000,
  parameter int EXT_LIMIT = 4000,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_low_i,
  input  logic              bus_owned_i,
  input  logic              cmd_start_i,
  input  logic [1:0]        rx_mode_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic [REM_W-1:0]  rx_remain_i,
  input  logic              rx_flush_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic              irq_en_i,
  input  logic              rd_en_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic [N_TMR-1:0]  tmr_exp_w;
  logic              tmr_run_w;
  logic              rx_hi_w;
  logic [STAT_W-1:0] set_w;
  logic [STAT_W-1:0] stat_w;

  assign tmr_run_w = scl_low_i & bus_owned_i;

  // timer 0: clock-low limit, timer 1: extended limit
  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    localparam int LIM = (t == 0) ? LOW_LIMIT : EXT_LIMIT;
    tw_low_timer #(.LIMIT(LIM)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (tmr_run_w),
      .expire_o(tmr_exp_w[t])
    );
  end

  tw_rx_hi #(
    .DEPTH   (DEPTH),
    .HI_LEVEL(HI_LEVEL),
    .REM_W   (REM_W)
  ) u_rx_hi (
    .rx_mode_i  (rx_mode_i),
    .rx_count_i (rx_count_i),
    .rx_remain_i(rx_remain_i),
    .hi_o       (rx_hi_w)
  );

  assign set_w = {tmr_exp_w[0], tmr_exp_w[1], 1'b0, evt_i, info_i};

  tw_stat_reg u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (rd_en_i | cmd_start_i),
    .set_i (set_w),
    .lvl_i (rx_hi_w & ~rx_flush_i),
    .stat_o(stat_w)
  );

  tw_irq_out #(.SRC_W(STAT_W - SRC_LSB)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (irq_en_i),
    .src_i (stat_w[STAT_W-1:SRC_LSB]),
    .irq_o (irq_o)
  );

  assign rd_data_o = {{(REG_W - STAT_W){1'b0}}, stat_w};
endmodule

// File: rtl/tw_irq_status_chk.sv
module tw_irq_status_chk
  import tw_irq_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int REM_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_low_i,
  input logic              bus_owned_i,
  input logic              cmd_start_i,
  input logic              rx_flush_i,
  input logic [EVT_W-1:0]  evt_i,
  input logic [INFO_W-1:0] info_i,
  input logic              irq_en_i,
  input logic              rd_en_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              irq_o
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:STAT_W] == '0);

  // R5
  evt_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((rd_data_o[12:4] & $past(evt_i)) == $past(evt_i)));

  // R3
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && evt_i == '0 && info_i == '0) |=> (rd_data_o[12:0] == '0));

  // R4
  cmd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_i && evt_i == '0 && info_i == '0) |=> (rd_data_o[12:0] == '0));

  // R9
  flush_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_i |=> !rd_data_o[BIT_RXHI]);

  // R6
  tlow_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_owned_i && !rd_data_o[BIT_TLOW]) |=> !rd_data_o[BIT_TLOW]);

  // R7
  text_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_low_i && !rd_data_o[BIT_TEXT]) |=> !rd_data_o[BIT_TEXT]);

  // R10
  irq_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o);

  // R10
  irq_no_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[STAT_W-1:SRC_LSB] == '0) |=> !irq_o);
endmodule

bind tw_irq_status tw_irq_status_chk #(.CNT_W(CNT_W), .REM_W(REM_W)) chk_i (.*);

// File: tb/tw_irq_status_tb_top.sv
`timescale 1ns/1ps
module tw_irq_status_tb_top;
  localparam int DEPTH = 8;
  localparam int LOWL  = 12;
  localparam int EXTL  = 30;
  localparam int CW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_low = 0, owned = 0, cmd = 0, flush = 0, irq_en = 0, rd = 0;
  logic [1:0]  mode = 0;
  logic [CW-1:0] cnt = 0;
  logic [15:0] rem = 0;
  logic [8:0]  evt = 0;
  logic [3:0]  info = 0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  tw_irq_status #(
    .DEPTH(DEPTH), .HI_LEVEL(4), .REM_W(16),
    .LOW_LIMIT(LOWL), .EXT_LIMIT(EXTL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_low_i(scl_low), .bus_owned_i(owned),
    .cmd_start_i(cmd), .rx_mode_i(mode), .rx_count_i(cnt), .rx_remain_i(rem),
    .rx_flush_i(flush), .evt_i(evt), .info_i(info), .irq_en_i(irq_en),
    .rd_en_i(rd), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  cnt;
    logic [7:0]  rem;
    logic [8:0]  evt;
    logic [3:0]  info;
    logic [15:0] exp;
  } vec_t;

  // each vector issued together with a new command: status = its sets only
  localparam vec_t TBL [8] = '{
    '{2'd1, 4'd4, 8'd5,  9'h000, 4'h0, 16'h2000},
    '{2'd1, 4'd4, 8'd4,  9'h001, 4'h0, 16'h0010},
    '{2'd2, 4'd3, 8'd10, 9'h000, 4'h5, 16'h0005},
    '{2'd0, 4'd6, 8'd9,  9'h100, 4'h0, 16'h1000},
    '{2'd3, 4'd8, 8'd1,  9'h0AA, 4'h0, 16'h2AA0},
    '{2'd2, 4'd7, 8'd1,  9'h000, 4'h8, 16'h0008},
    '{2'd2, 4'd7, 8'd2,  9'h1FF, 4'hF, 16'h3FFF},
    '{2'd3, 4'd5, 8'd3,  9'h000, 4'h0, 16'h0000}
  };

  initial begin : watchdog
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    tick(3);
    // R1 reset state
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    tick(1);

    // R8 R4 R5 table walk
    foreach (TBL[i]) begin
      mode = TBL[i].mode; cnt = CW'(TBL[i].cnt); rem = 16'(TBL[i].rem);
      evt = TBL[i].evt; info = TBL[i].info; cmd = 1'b1;
      tick(1);
      check($sformatf("R8 vector %0d", i), rdata, {16'h0, TBL[i].exp});
      cmd = 0; evt = 0; info = 0; mode = 0;
    end
    tick(1);
    check("R9 mode off clears rx bit", rdata & 32'h2000, 32'h0);

    // R2 sticky and reserved zero
    cmd = 1; tick(1); cmd = 0;
    evt = 9'h004; info = 4'h2; tick(1); evt = 0; info = 0;
    tick(3);
    check("R2 sticky bits", rdata, 32'h0000_0042);

    // R3 read shows old value, then clears
    rd = 1;
    check("R3 read value", rdata, 32'h0000_0042);
    tick(1); rd = 0;
    check("R3 cleared after read", rdata, 32'h0);

    // R5 set wins over read clear
    evt = 9'h001; tick(1); evt = 0;
    rd = 1; evt = 9'h010; tick(1); rd = 0; evt = 0;
    check("R5 set wins on read", rdata, 32'h0000_0100);

    // R10 irq timing
    rd = 1; tick(1); rd = 0;
    irq_en = 1; evt = 9'h002; tick(1); evt = 0;
    check("R10 irq not yet", {31'b0, irq}, 32'h0);
    tick(1);
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    irq_en = 0; tick(1);
    check("R10 irq disabled", {31'b0, irq}, 32'h0);
    irq_en = 1; tick(1);
    check("R10 irq re-enabled", {31'b0, irq}, 32'h1);
    rd = 1; tick(1); rd = 0;
    check("R10 irq one cycle after clear", {31'b0, irq}, 32'h1);
    tick(1);
    check("R10 irq dropped", {31'b0, irq}, 32'h0);

    // R2 info bits are not interrupt sources
    info = 4'hF; tick(1); info = 0; tick(2);
    check("R2 info no irq", {31'b0, irq}, 32'h0);
    cmd = 1; tick(1); cmd = 0;

    // R6 R7 timeouts
    scl_low = 1; owned = 1;
    tick(LOWL - 1);
    check("R6 before limit", rdata & 32'hC000, 32'h0);
    tick(1);
    check("R6 at limit", rdata & 32'hC000, 32'h8000);
    tick(1);
    check("R10 irq from timeout", {31'b0, irq}, 32'h1);
    rd = 1; tick(1); rd = 0;
    tick(EXTL - LOWL - 3);
    check("R6 single pulse per low period", rdata & 32'h8000, 32'h0);
    check("R7 before limit", rdata & 32'h4000, 32'h0);
    tick(1);
    check("R7 at limit", rdata & 32'h4000, 32'h4000);
    scl_low = 0; cmd = 1; tick(1); cmd = 0;
    check("R4 new command clears timeouts", rdata, 32'h0);

    // R6 restart on break, and no count when not owned
    scl_low = 1; tick(LOWL - 2); scl_low = 0; tick(1);
    scl_low = 1; tick(LOWL - 2);
    check("R6 restart after release", rdata & 32'hC000, 32'h0);
    scl_low = 0; tick(1);
    owned = 0; scl_low = 1; tick(EXTL + 5);
    check("R7 not owned no timeout", rdata & 32'hC000, 32'h0);
    scl_low = 0;

    // R9 level tracking and flush
    mode = 2'd1; cnt = CW'(4); rem = 16'd5; tick(1);
    check("R8 rx high set", rdata & 32'h2000, 32'h2000);
    rd = 1; tick(1); rd = 0;
    check("R5 rx high survives read", rdata & 32'h2000, 32'h2000);
    flush = 1; tick(1); flush = 0;
    check("R9 flush clears", rdata & 32'h2000, 32'h0);
    tick(1);
    check("R9 follows condition again", rdata & 32'h2000, 32'h2000);
    rem = 16'd4; tick(1);
    check("R9 clears when false", rdata & 32'h2000, 32'h0);
    cnt = CW'(8); rem = 16'd1; tick(1);
    check("R8 full fifo", rdata & 32'h2000, 32'h2000);
    mode = 0; tick(1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule